// File: doc/BRIEF.md
# Modulo-7 Counter with Terminal-State Clear

This block is a small binary up-counter, three bits wide by default, whose short cycle comes from clearing after the fact. On its own it would run through every code and wrap, giving a modulo-8 count. A decoder watches for the code with every bit set and drives an active-low clear. On the next enabled step, that clear returns all stages to zero together.

The all-ones code is therefore a transient. It is entered from 110 and lasts exactly one enabled step. During that step `clr_flag` is high. The visible count runs 000 up to 110 and then returns to 000.

A strap input, `wrap8_sel`, disarms the clear path. The counter then counts plain modulo-8 with the flag held low. Everything is synchronous to `clk`, including the active-low reset, which overrides all other inputs.

Top module: `mod7_clr_counter`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `count` becomes 000 after that edge and `clr_flag` is low. This holds whatever `cnt_en` and `wrap8_sel` are.
- R2: When `cnt_en` is high at a rising edge and `count` is below 111, `count` becomes `count + 1` in plain binary after that edge.
- R3: When `cnt_en` is low at a rising edge and reset is inactive, `count` keeps its value. This includes the value 111.
- R4: With `wrap8_sel` low, `clr_flag` is high for as long as `count` is 111. The next enabled edge then sets `count` to 000.
- R5: `clr_flag` is low whenever `count` is not 111.
- R6: With `wrap8_sel` high, `clr_flag` stays low in every state. From 111, an enabled edge wraps `count` to 000, so the counter passes through 8 distinct codes in 8 enabled steps.
- R7: With `wrap8_sel` low, 8 enabled steps starting from 000 return the count to 000. Along the way, 7 distinct codes are seen with `clr_flag` low and one code, 111, is seen with `clr_flag` high.
- R8: Reset takes priority over the clear path. With `count` at 111 and `cnt_en` high, a low `rst_n` still gives 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low, highest priority |
| cnt_en | input | 1 | Count enable; low holds the state |
| wrap8_sel | input | 1 | Strap; high disarms the terminal clear (plain modulo-8) |
| count | output | 3 | Present counter state |
| clr_flag | output | 1 | High while the terminal clear is being forced |

## Verification
The assertions assume that `wrap8_sel` is a strap that changes only while reset is held or while `cnt_en` is low. They also assume that every input is settled at each rising edge. The stimulus drives all inputs on the falling edge and changes the strap only between scenarios, with the count held or in reset. No property therefore sees a strap edge coinciding with a count step. The properties that track the count's history are disabled during reset, so they only look back across cycles that have passed since reset released.

// File: rtl/mod7_clr_pkg.sv
package mod7_clr_pkg;

  // Plain binary successor of a counter code, wrapping naturally.
  function automatic logic [7:0] next_code8(input logic [7:0] q, input int unsigned w);
    logic [7:0] mask;
    mask = 8'((9'd1 << w) - 9'd1);
    return (q + 8'd1) & mask;
  endfunction

  // True when every one of the low w bits is set.
  function automatic logic all_ones8(input logic [7:0] q, input int unsigned w);
    logic [7:0] mask;
    mask = 8'((9'd1 << w) - 9'd1);
    return (q & mask) == mask;
  endfunction

endpackage

// File: rtl/mod7_term_decode.sv
module mod7_term_decode #(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] q,
  input  logic             wrap8_sel,
  output logic             term_hit,
  output logic             clr_n
);

  // AND chain across the stages, one link per bit.
  logic [WIDTH-1:0] chain;

  assign chain[0] = q[0];
  genvar gi;
  generate
    for (gi = 1; gi < WIDTH; gi++) begin : g_chain
      assign chain[gi] = chain[gi-1] & q[gi];
    end
  endgenerate

  assign term_hit = chain[WIDTH-1];
  // Active-low clear, armed only when the strap is low.
  assign clr_n    = ~(term_hit & ~wrap8_sel);

endmodule

// File: rtl/mod7_count_core.sv
module mod7_count_core
  import mod7_clr_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             clr_n,
  output logic [WIDTH-1:0] q,
  output logic             step_clr,
  output logic             step_inc
);

  localparam int PADW = 8;

  logic [WIDTH-1:0] q_nxt;

  assign step_clr = cnt_en & ~clr_n;
  assign step_inc = cnt_en & clr_n;

  always_comb begin
    q_nxt = q;
    if (step_clr)
      q_nxt = '0;
    else if (step_inc)
      q_nxt = WIDTH'(next_code8(PADW'(q), WIDTH));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assert_reset_zero_R1: assert property (@(posedge clk) !rst_n |=> q == '0);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(q));

  assert_increment_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_inc && !all_ones8(PADW'(q), WIDTH)) |=> q == WIDTH'($past(q) + 1'b1));

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_clr |=> q == '0);

endmodule

// File: rtl/mod7_clr_counter.sv
module mod7_clr_counter #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             wrap8_sel,
  output logic [WIDTH-1:0] count,
  output logic             clr_flag
);

  logic term_hit;
  logic clr_n;
  logic step_clr;
  logic step_inc;

  mod7_term_decode #(.WIDTH(WIDTH)) u_decode (
    .q         (count),
    .wrap8_sel (wrap8_sel),
    .term_hit  (term_hit),
    .clr_n     (clr_n)
  );

  mod7_count_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .clr_n    (clr_n),
    .q        (count),
    .step_clr (step_clr),
    .step_inc (step_inc)
  );

  assign clr_flag = ~clr_n;

  // R5: flag only on the all-ones code
  assert_flag_terminal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flag |-> $countones(count) == WIDTH);

  // R6: disarmed strap never flags
  assert_strap_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap8_sel |-> !clr_flag);

  // R8: reset beats the clear path
  assert_reset_priority_R8: assert property (@(posedge clk)
    (!rst_n && term_hit && cnt_en) |=> (count == '0 && !clr_flag));

  // R7: the step into all-ones comes only from the code just below
  assert_enter_terminal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_inc && $countones(count) == WIDTH - 1 && !count[0]) |=> term_hit);

endmodule

// File: tb/mod7_clr_counter_tb.sv
module mod7_clr_counter_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic       wrap8_sel = 1'b0;
  logic [2:0] count;
  logic       clr_flag;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mod7_clr_counter #(.WIDTH(3)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .wrap8_sel (wrap8_sel),
    .count     (count),
    .clr_flag  (clr_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive inputs on the falling edge, then sample 1 ns after the next rising edge.
  task automatic cycle(input bit rn, input bit en);
    @(negedge clk);
    rst_n  = rn;
    cnt_en = en;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    cycle(1'b0, 1'b0);
    cycle(1'b1, 1'b0);
  endtask

  task automatic t_reset_R1();
    cycle(1'b0, 1'b1);
    check(count == 3'd0, "R1 count", count, 0);
    check(clr_flag == 1'b0, "R1 flag", clr_flag, 0);
  endtask

  task automatic t_count_up_R2();
    wrap8_sel = 1'b0;
    do_reset();
    for (int i = 1; i <= 6; i++) begin
      cycle(1'b1, 1'b1);
      check(count == 3'(i), "R2 increment", count, i);
      check(clr_flag == 1'b0, "R5 flag low", clr_flag, 0);
    end
  endtask

  task automatic t_hold_R3();
    wrap8_sel = 1'b0;
    do_reset();
    cycle(1'b1, 1'b1);
    cycle(1'b1, 1'b1);
    cycle(1'b1, 1'b0);
    cycle(1'b1, 1'b0);
    check(count == 3'd2, "R3 hold mid", count, 2);
    for (int i = 0; i < 5; i++) cycle(1'b1, 1'b1);
    check(count == 3'd7, "R3 reach 111", count, 7);
    for (int i = 0; i < 3; i++) begin
      cycle(1'b1, 1'b0);
      check(count == 3'd7, "R3 hold 111", count, 7);
      check(clr_flag == 1'b1, "R4 flag while held", clr_flag, 1);
    end
  endtask

  task automatic t_clear_R4();
    wrap8_sel = 1'b0;
    do_reset();
    for (int i = 0; i < 7; i++) cycle(1'b1, 1'b1);
    check(count == 3'd7, "R4 terminal", count, 7);
    check(clr_flag == 1'b1, "R4 flag high", clr_flag, 1);
    cycle(1'b1, 1'b1);
    check(count == 3'd0, "R4 cleared", count, 0);
    check(clr_flag == 1'b0, "R5 flag after clear", clr_flag, 0);
  endtask

  task automatic t_mod8_R6();
    wrap8_sel = 1'b1;
    do_reset();
    for (int i = 1; i <= 8; i++) begin
      cycle(1'b1, 1'b1);
      check(count == 3'(i % 8), "R6 mod8 count", count, i % 8);
      check(clr_flag == 1'b0, "R6 flag quiet", clr_flag, 0);
    end
    wrap8_sel = 1'b0;
  endtask

  task automatic t_period_R7();
    int seen_plain;
    int flagged;
    bit [7:0] mask;
    wrap8_sel = 1'b0;
    do_reset();
    seen_plain = 0;
    flagged = 0;
    mask = 8'h01;
    for (int i = 0; i < 8; i++) begin
      cycle(1'b1, 1'b1);
      if (clr_flag) flagged++;
      else if (!mask[count]) begin
        mask[count] = 1'b1;
      end
    end
    for (int b = 0; b < 8; b++) if (mask[b]) seen_plain++;
    check(count == 3'd0, "R7 period return", count, 0);
    check(seen_plain == 7, "R7 plain states", seen_plain, 7);
    check(flagged == 1, "R7 flagged steps", flagged, 1);
  endtask

  task automatic t_reset_priority_R8();
    wrap8_sel = 1'b0;
    do_reset();
    for (int i = 0; i < 7; i++) cycle(1'b1, 1'b1);
    check(count == 3'd7, "R8 setup", count, 7);
    cycle(1'b0, 1'b1);
    check(count == 3'd0, "R8 reset wins", count, 0);
    check(clr_flag == 1'b0, "R8 flag", clr_flag, 0);
    cycle(1'b1, 1'b1);
    check(count == 3'd1, "R8 resume", count, 1);
  endtask

  initial begin
    cycle(1'b0, 1'b0);
    t_reset_R1();
    t_count_up_R2();
    t_hold_R3();
    t_clear_R4();
    t_mod8_R6();
    t_period_R7();
    t_reset_priority_R8();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

endmodule